// File: doc/BRIEF.md
# Power Rail Sequencer and Fault Supervisor

This block sequences the enables of three regulators feeding a display panel (an auxiliary positive rail, a main positive rail and a negative rail) and supervises them through comparator-style status flags. An auxiliary enable input switches the auxiliary rail on its own. A main enable input brings up the main positive rail at once, with a reduced switch current limit. After a fixed delay it brings up the negative rail as well. All analog comparison happens outside the block; it only sees single-bit good, undervoltage and over-threshold flags.

Fault handling depends on the phase. During start-up, two fixed deadlines are checked, one at the negative-rail delay point and one at the end of the start window. During normal operation, only a flag that persists for a programmable filter time counts as a short. Any fault, and the over-temperature flag, puts the block into a latched shutdown. In that state every rail enable is off, every discharge output is on, and a fault-cause code is presented. The latch clears on an undervoltage indication or when the main enable goes low. All times are counted in clock cycles. Every control and status pin is a plain level signal; there is no streaming interface.

Top module: `rail_seq_supervisor`

## Requirements
- R1: `aux_rail_en_o` equals the value of `aux_en_i && !uvlo_i` sampled at the previous clock edge. The exception is while the fault latch is set, when it is 0. It does not depend on the main enable or on the state of the other rails.
- R2: When `main_en_i` is sampled high from the off state, `pos_rail_en_o` rises on the next cycle. `neg_rail_en_o` rises exactly `NEG_DELAY_CYC` cycles after `pos_rail_en_o`.
- R3: Consider the edge at which `pos_rail_en_o` has been high for `NEG_DELAY_CYC` cycles. If at that edge `pos_good_i` is low or `neg_over_i` is high, the block latches with fault code 1 (start-up).
- R4: Consider the edge at which `pos_rail_en_o` has been high for `START_WIN_CYC` cycles. If `neg_good_i` is low there, the block latches with code 1. Otherwise it enters normal operation.
- R5: In normal operation, `pos_uv_i` or `neg_over_i` sampled high on `FILT_CYC` consecutive edges latches code 2 (operating short). A shorter run of high samples is ignored.
- R6: While latched, `pos_rail_en_o`, `neg_rail_en_o` and `aux_rail_en_o` are 0 and `fault_code_o` holds the cause. When not latched, `fault_code_o` is 0. The codes are 0 none, 1 start-up, 2 operating short, 3 thermal.
- R7: The latch is cleared on the edge after `uvlo_i` is sampled high. It is also cleared when `main_en_i` is sampled low, provided `otemp_i` is low. Holding `main_en_i` high keeps the block latched. A later high on `main_en_i` restarts the sequence.
- R8: `otemp_i` sampled high outside the latch, with `uvlo_i` low, latches code 3 on that edge. This applies in any state.
- R9: Each discharge output (`aux_dischg_o`, `pos_dischg_o`, `neg_dischg_o`) is the inverse of its rail's enable output.
- R10: `pos_ilim_low_o` is high during start-up from the first cycle of `pos_rail_en_o`. It falls one cycle after `pos_good_i` is first sampled high, or when the `NEG_DELAY_CYC` point is reached, whichever comes first. It is 0 at all other times.
- R11: `main_en_i` sampled low during start-up or normal operation turns both main rails off on the next cycle, with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_en_i | input | 1 | Auxiliary rail enable request |
| main_en_i | input | 1 | Main positive and negative rail enable request |
| uvlo_i | input | 1 | Supply below undervoltage lockout threshold |
| otemp_i | input | 1 | Over-temperature flag |
| pos_good_i | input | 1 | Main positive rail in regulation |
| pos_uv_i | input | 1 | Main positive rail below short-circuit threshold |
| neg_good_i | input | 1 | Negative rail in regulation |
| neg_over_i | input | 1 | Negative rail above its threshold level |
| aux_rail_en_o | output | 1 | Auxiliary regulator enable |
| pos_rail_en_o | output | 1 | Main positive regulator enable |
| neg_rail_en_o | output | 1 | Negative regulator enable |
| pos_ilim_low_o | output | 1 | Reduced switch current limit for the positive rail |
| aux_dischg_o | output | 1 | Auxiliary output discharge |
| pos_dischg_o | output | 1 | Positive output discharge |
| neg_dischg_o | output | 1 | Negative output discharge |
| fault_code_o | output | 2 | Latched fault cause |

## Verification
The hardest cases to reach are the filter boundaries in normal operation. A flag that goes high for one cycle fewer than the filter time must leave the rails alone, and a run of exactly the filter time must trip. Getting there requires first passing both start-up deadlines with the right flag values. The stimulus therefore walks a full start-up with the good flags set at chosen cycles. It then applies runs of exactly `FILT_CYC-1` and `FILT_CYC` high samples, once on each short flag. A behavioural reference model in the bench, compared on every cycle, also covers the clearing of the latch. This includes a thermal flag that is still present when the main enable drops.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_LATCH = 2'd3
  } rss_state_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_STARTUP = 2'd1,
    FC_SHORT   = 2'd2,
    FC_THERMAL = 2'd3
  } rss_fault_e;

  localparam int unsigned N_SHORT_FLAGS = 2;

endpackage

// File: rtl/rss_persist_filter.sv
module rss_persist_filter #(
  parameter int unsigned CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (en_i && flag_i && run_cnt != LAST) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  assign trip_o = en_i && flag_i && (run_cnt == LAST);
endmodule

// File: rtl/rss_seq_fsm.sv
module rss_seq_fsm
  import rss_pkg::*;
#(
  parameter int unsigned NEG_DELAY_CYC = 500000,
  parameter int unsigned START_WIN_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_en_i,
  input  logic       uvlo_i,
  input  logic       otemp_i,
  input  logic       pos_good_i,
  input  logic       neg_over_i,
  input  logic       neg_good_i,
  input  logic       short_trip_i,
  output logic       run_o,
  output logic       latched_o,
  output logic       pos_en_o,
  output logic       neg_en_o,
  output logic       ilim_low_o,
  output logic [1:0] fault_code_o
);
  localparam int unsigned TW = $clog2(START_WIN_CYC + 1);
  localparam logic [TW-1:0] T_DLY  = TW'(NEG_DELAY_CYC);
  localparam logic [TW-1:0] T_CHK1 = TW'(NEG_DELAY_CYC - 1);
  localparam logic [TW-1:0] T_CHK2 = TW'(START_WIN_CYC - 1);

  rss_state_e    state_q, state_d;
  rss_fault_e    code_q, code_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          rel_q, rel_d;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    tmr_d   = tmr_q;
    rel_d   = rel_q;
    if (uvlo_i) begin
      state_d = ST_OFF;
      code_d  = FC_NONE;
    end else if (state_q == ST_LATCH) begin
      if (!main_en_i && !otemp_i) begin
        state_d = ST_OFF;
        code_d  = FC_NONE;
      end
    end else if (otemp_i) begin
      state_d = ST_LATCH;
      code_d  = FC_THERMAL;
    end else if (!main_en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_START;
          tmr_d   = '0;
          rel_d   = 1'b0;
        end
        ST_START: begin
          if (pos_good_i) rel_d = 1'b1;
          if (tmr_q == T_CHK1 && (!pos_good_i || neg_over_i)) begin
            state_d = ST_LATCH;
            code_d  = FC_STARTUP;
          end else if (tmr_q == T_CHK2) begin
            if (neg_good_i) begin
              state_d = ST_RUN;
            end else begin
              state_d = ST_LATCH;
              code_d  = FC_STARTUP;
            end
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (short_trip_i) begin
            state_d = ST_LATCH;
            code_d  = FC_SHORT;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      code_q  <= FC_NONE;
      tmr_q   <= '0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      tmr_q   <= tmr_d;
      rel_q   <= rel_d;
    end
  end

  assign run_o        = (state_q == ST_RUN);
  assign latched_o    = (state_q == ST_LATCH);
  assign pos_en_o     = (state_q == ST_START) || (state_q == ST_RUN);
  assign neg_en_o     = ((state_q == ST_START) && (tmr_q >= T_DLY)) || (state_q == ST_RUN);
  assign ilim_low_o   = (state_q == ST_START) && (tmr_q < T_DLY) && !rel_q;
  assign fault_code_o = latched_o ? code_q : FC_NONE;
endmodule

// File: rtl/rss_aux_gate.sv
module rss_aux_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic aux_en_i,
  input  logic uvlo_i,
  input  logic latched_i,
  output logic aux_en_o
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= aux_en_i && !uvlo_i;
  end

  assign aux_en_o = req_q && !latched_i;
endmodule

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor
  import rss_pkg::*;
#(
  parameter int unsigned NEG_DELAY_CYC = 500000,
  parameter int unsigned START_WIN_CYC = 1000000,
  parameter int unsigned FILT_CYC      = 150000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_en_i,
  input  logic       main_en_i,
  input  logic       uvlo_i,
  input  logic       otemp_i,
  input  logic       pos_good_i,
  input  logic       pos_uv_i,
  input  logic       neg_good_i,
  input  logic       neg_over_i,
  output logic       aux_rail_en_o,
  output logic       pos_rail_en_o,
  output logic       neg_rail_en_o,
  output logic       pos_ilim_low_o,
  output logic       aux_dischg_o,
  output logic       pos_dischg_o,
  output logic       neg_dischg_o,
  output logic [1:0] fault_code_o
);
  logic                     run;
  logic                     latched;
  logic [N_SHORT_FLAGS-1:0] short_flags;
  logic [N_SHORT_FLAGS-1:0] short_trips;

  assign short_flags = {neg_over_i, pos_uv_i};

  for (genvar g = 0; g < N_SHORT_FLAGS; g++) begin : g_filt
    rss_persist_filter #(.CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (run),
      .flag_i (short_flags[g]),
      .trip_o (short_trips[g])
    );
  end

  rss_seq_fsm #(
    .NEG_DELAY_CYC (NEG_DELAY_CYC),
    .START_WIN_CYC (START_WIN_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_en_i    (main_en_i),
    .uvlo_i       (uvlo_i),
    .otemp_i      (otemp_i),
    .pos_good_i   (pos_good_i),
    .neg_over_i   (neg_over_i),
    .neg_good_i   (neg_good_i),
    .short_trip_i (|short_trips),
    .run_o        (run),
    .latched_o    (latched),
    .pos_en_o     (pos_rail_en_o),
    .neg_en_o     (neg_rail_en_o),
    .ilim_low_o   (pos_ilim_low_o),
    .fault_code_o (fault_code_o)
  );

  rss_aux_gate u_aux (
    .clk       (clk),
    .rst_n     (rst_n),
    .aux_en_i  (aux_en_i),
    .uvlo_i    (uvlo_i),
    .latched_i (latched),
    .aux_en_o  (aux_rail_en_o)
  );

  assign aux_dischg_o = !aux_rail_en_o;
  assign pos_dischg_o = !pos_rail_en_o;
  assign neg_dischg_o = !neg_rail_en_o;
endmodule

// File: rtl/rss_checker.sv
module rss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       aux_en_i,
  input logic       uvlo_i,
  input logic       otemp_i,
  input logic       aux_rail_en_o,
  input logic       pos_rail_en_o,
  input logic       neg_rail_en_o,
  input logic       pos_ilim_low_o,
  input logic [1:0] fault_code_o
);
  AST_AUX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rail_en_o |-> $past(aux_en_i)); // R1

  AST_NEG_NEEDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    neg_rail_en_o |-> pos_rail_en_o); // R2

  AST_LATCH_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code_o != 2'd0) |-> !(pos_rail_en_o || neg_rail_en_o || aux_rail_en_o)); // R6

  AST_UVLO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (fault_code_o == 2'd0) && !pos_rail_en_o); // R7

  AST_THERMAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (otemp_i && !uvlo_i && pos_rail_en_o) |=> (fault_code_o == 2'd3)); // R8

  AST_ILIM_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
    pos_ilim_low_o |-> (pos_rail_en_o && !neg_rail_en_o)); // R10
endmodule

bind rail_seq_supervisor rss_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .aux_en_i       (aux_en_i),
  .uvlo_i         (uvlo_i),
  .otemp_i        (otemp_i),
  .aux_rail_en_o  (aux_rail_en_o),
  .pos_rail_en_o  (pos_rail_en_o),
  .neg_rail_en_o  (neg_rail_en_o),
  .pos_ilim_low_o (pos_ilim_low_o),
  .fault_code_o   (fault_code_o)
);

// File: tb/rail_seq_supervisor_tb.sv
module rail_seq_supervisor_tb;
  localparam int T1 = 20;
  localparam int T2 = 40;
  localparam int TF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_en = 0, main_en = 0, uvlo = 0, otemp = 0;
  logic pos_good = 0, pos_uv = 0, neg_good = 0, neg_over = 0;
  logic aux_o, pos_o, neg_o, ilim_o, auxd_o, posd_o, negd_o;
  logic [1:0] code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rail_seq_supervisor #(.NEG_DELAY_CYC(T1), .START_WIN_CYC(T2), .FILT_CYC(TF)) u_dut (
    .clk(clk), .rst_n(rst_n), .aux_en_i(aux_en), .main_en_i(main_en), .uvlo_i(uvlo),
    .otemp_i(otemp), .pos_good_i(pos_good), .pos_uv_i(pos_uv), .neg_good_i(neg_good),
    .neg_over_i(neg_over), .aux_rail_en_o(aux_o), .pos_rail_en_o(pos_o),
    .neg_rail_en_o(neg_o), .pos_ilim_low_o(ilim_o), .aux_dischg_o(auxd_o),
    .pos_dischg_o(posd_o), .neg_dischg_o(negd_o), .fault_code_o(code_o));

  // Behavioural reference: phase 0 off, 1 starting, 2 running, 3 latched
  int m_ph = 0, m_t = 0, m_code = 0, m_cp = 0, m_cn = 0;
  bit m_rel = 0, m_aux = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit tp, tn;
      m_aux = aux_en && !uvlo;
      tp = (m_ph == 2) && pos_uv && (m_cp == TF - 1);
      tn = (m_ph == 2) && neg_over && (m_cn == TF - 1);
      if (m_ph == 2) begin
        m_cp = (pos_uv && m_cp < TF - 1) ? m_cp + 1 : 0;
        m_cn = (neg_over && m_cn < TF - 1) ? m_cn + 1 : 0;
      end else begin
        m_cp = 0; m_cn = 0;
      end
      if (uvlo) begin m_ph = 0; m_code = 0; end
      else if (m_ph == 3) begin
        if (!main_en && !otemp) begin m_ph = 0; m_code = 0; end
      end
      else if (otemp) begin m_ph = 3; m_code = 3; end
      else if (!main_en) m_ph = 0;
      else if (m_ph == 0) begin m_ph = 1; m_t = 0; m_rel = 0; end
      else if (m_ph == 1) begin
        if (pos_good) m_rel = 1;
        if (m_t == T1 - 1 && (!pos_good || neg_over)) begin m_ph = 3; m_code = 1; end
        else if (m_t == T2 - 1) begin
          if (neg_good) m_ph = 2; else begin m_ph = 3; m_code = 1; end
        end else m_t++;
      end
      else if (m_ph == 2 && (tp || tn)) begin m_ph = 3; m_code = 2; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_pos, e_neg, e_aux;
      e_pos = (m_ph == 1) || (m_ph == 2);
      e_neg = (m_ph == 1 && m_t >= T1) || (m_ph == 2);
      e_aux = m_aux && (m_ph != 3);
      chk("R1 aux enable", aux_o, e_aux);
      chk("R2 pos enable", pos_o, e_pos);
      chk("R2 neg enable", neg_o, e_neg);
      chk("R10 current limit", ilim_o, (m_ph == 1) && (m_t < T1) && !m_rel);
      chk("R9 discharge", {auxd_o, posd_o, negd_o}, {!e_aux, !e_pos, !e_neg});
      chk("R6 fault code", code_o, (m_ph == 3) ? m_code : 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  // Walk a clean start-up to normal operation
  task automatic good_start();
    main_en = 1; cyc(1);
    cyc(4); pos_good = 1; cyc(25); neg_good = 1;
    cyc(15);
  endtask

  task automatic all_off();
    main_en = 0; pos_good = 0; neg_good = 0; pos_uv = 0; neg_over = 0; otemp = 0;
    cyc(3);
  endtask

  initial begin
    int rise_pos, rise_neg;
    cyc(2);
    chk("R6 reset code", code_o, 0);
    chk("R2 reset rails", {pos_o, neg_o, aux_o}, 0);
    rst_n = 1; cyc(1);

    // R1: aux independent of main
    aux_en = 1; cyc(2);
    chk("R1 aux on alone", aux_o, 1);
    chk("R11 main rails stay off", pos_o, 0);
    aux_en = 0; cyc(2);
    chk("R1 aux off", aux_o, 0);
    aux_en = 1;

    // R2/R10 start-up timing
    main_en = 1; rise_pos = -1; rise_neg = -1;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (i == 8) pos_good = 1;
      if (i == 30) neg_good = 1;
      if (pos_o && rise_pos < 0) rise_pos = i;
      if (neg_o && rise_neg < 0) rise_neg = i;
    end
    chk("R2 neg delay", rise_neg - rise_pos, T1);
    chk("R4 enters run, rails on", {pos_o, neg_o}, 2'b11);

    // R5: short run ignored, full run trips (positive flag)
    pos_uv = 1; cyc(TF - 1); pos_uv = 0; cyc(2);
    chk("R5 short glitch ignored", code_o, 0);
    pos_uv = 1; cyc(TF); pos_uv = 0; cyc(1);
    chk("R5 persistent undervoltage", code_o, 2);
    cyc(5);
    chk("R7 held while main high", code_o, 2);
    chk("R6 aux off in latch", aux_o, 0);
    all_off();
    chk("R7 cleared by main low", code_o, 0);

    // R5 negative flag
    good_start();
    neg_over = 1; cyc(TF - 1); neg_over = 0; cyc(1);
    chk("R5 neg glitch ignored", code_o, 0);
    neg_over = 1; cyc(TF + 1); neg_over = 0;
    chk("R5 neg over threshold", code_o, 2);
    all_off();

    // R3: positive rail never good
    main_en = 1; cyc(T1 + 3);
    chk("R3 pos not good at deadline", code_o, 1);
    all_off();

    // R3: negative over threshold at first deadline
    main_en = 1; pos_good = 1; neg_over = 1; cyc(T1 + 3);
    chk("R3 neg over at deadline", code_o, 1);
    all_off();

    // R4: negative never good
    main_en = 1; pos_good = 1; cyc(T2 + 3);
    chk("R4 neg not good at window end", code_o, 1);
    all_off();

    // R8 thermal in run, cleared by uvlo
    good_start();
    otemp = 1; cyc(1); otemp = 0; cyc(1);
    chk("R8 thermal latch", code_o, 3);
    uvlo = 1; cyc(1);
    chk("R7 uvlo clears", code_o, 0);
    uvlo = 0; cyc(2);
    chk("R7 restart after uvlo", pos_o, 1);

    // R8 thermal persists while main drops
    otemp = 1; cyc(1); main_en = 0; cyc(3);
    chk("R8 thermal holds latch", code_o, 3);
    otemp = 0; cyc(2);
    chk("R8 clears once cool", code_o, 0);

    // R11 main low during start-up
    main_en = 1; cyc(5); main_en = 0; cyc(1);
    chk("R11 main low stops rails", {pos_o, code_o}, 0);
    all_off();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule